// File: doc/BRIEF.md
# Lane Comma Synchronisation Controller

This block is the transmit-side link controller for a multi-lane serial converter interface. It watches an active-low synchronisation request from the receiver. It tells every lane's 8b/10b encoder what to send in each octet slot: the comma control character, an octet of the lane alignment sequence, or a framed sample octet. It also drives the encoder's control-character (K) flag and, for control characters, the octet code to encode.

A qualified request forces every lane back to commas. A qualified request is the sync input held low at two consecutive clock edges. When the receiver releases the request, the controller waits for the framer's end-of-frame flag. It then switches every lane at once, so the first non-comma octet is octet 0 of a frame. If the alignment option is enabled, the lanes first carry an alignment sequence spanning a fixed number of multiframes, and only then carry sample data. The multiframe length in frames is a configuration input. The content of the alignment sequence, apart from its boundary markers, comes from elsewhere. The framer supplies `frm_end` high on the last octet of every frame, one octet per lane per clock.

Top module: `link_sync_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and from then until a release, every lane shows select 0 (comma), K flag 1 and code 0xBC.
- R2: When `sync_n` is low at two consecutive clock edges, every lane shows the comma (select 0, K 1, code 0xBC) in the cycle after the second edge. A single low edge alone does not cause this.
- R3: In the data state, a `sync_n` low for exactly one clock edge is ignored, and the lanes keep showing data.
- R4: While in the comma state, the lanes keep sending commas for as long as `sync_n` stays low, whatever `frm_end` does.
- R5: The comma state is left only at a clock edge where `sync_n` is high and `frm_end` is high. A release in the middle of a frame keeps commas going up to and including the last octet of that frame.
- R6: With `cfg_align_en` low at the leaving edge, the lanes go straight from comma to data (select 2, K 0, code 0x00).
- R7: With `cfg_align_en` high at the leaving edge, the lanes show the alignment select (1) for exactly ALIGN_MF multiframes of `cfg_mf_len_m1`+1 frames each, then data.
- R8: During alignment, the first octet of each multiframe carries code 0x1C with K 1, and the last octet of each multiframe carries code 0x7C with K 1. The last-octet marker wins when the two coincide. All other alignment octets show K 0 and code 0x00.
- R9: The K flag is 1 exactly for commas and alignment markers, and 0 for data octets.
- R10: All lanes carry identical select, K and code values in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Active-low synchronisation request from the receiver |
| frm_end | input | 1 | Framer flag: current octet is the last of a frame |
| cfg_align_en | input | 1 | Insert the alignment sequence after a release |
| cfg_mf_len_m1 | input | MF_CNT_W | Frames per multiframe minus one |
| lane_sel | output | 2*NUM_LANES | Per-lane select: 0 comma, 1 alignment, 2 data |
| lane_k | output | NUM_LANES | Per-lane control-character flag to the encoder |
| lane_code | output | 8*NUM_LANES | Per-lane control octet code (0 when not a control character) |

## Verification
The hardest situation to reach is a release that falls at an arbitrary octet within a frame, combined with an alignment sequence whose multiframe markers fall at different frame and multiframe sizes. The frame and multiframe sizes include one-octet frames, where the start and end markers land on the same octet. The bench sweeps frame length, multiframe length, the alignment enable and the release phase within the frame. For each combination it drives a comma request, releases at that phase, and then runs through alignment into data. In data it also injects a one-edge glitch and a two-edge request.

// File: rtl/link_sync_pkg.sv
// Package: shared types and control-octet codes for the lane sync controller.
// Assumes one octet per lane per clock; select encoding is visible at the ports.
package link_sync_pkg;

    // Per-lane octet source selection seen by the encoder mux.
    typedef enum logic [1:0] {
        SEL_COMMA = 2'd0,
        SEL_ALIGN = 2'd1,
        SEL_DATA  = 2'd2
    } lane_sel_e;

    // Link-level state of the controller.
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_DATA  = 2'd2
    } link_st_e;

    // Control octet codes handed to the 8b/10b encoder with K asserted.
    localparam logic [7:0] CODE_COMMA    = 8'hBC; // K28.5
    localparam logic [7:0] CODE_MF_START = 8'h1C; // K28.0
    localparam logic [7:0] CODE_MF_END   = 8'h7C; // K28.3

    // Bundle of what one lane transmits in a cycle.
    typedef struct packed {
        lane_sel_e  sel;
        logic       k;
        logic [7:0] code;
    } lane_ctl_t;

endpackage

// File: rtl/sync_req_filter.sv
// Module: sync_req_filter
// Qualifies the receiver's active-low sync input: a request is reported only
// when the input is low at the current edge and was low at the previous edge.
// Assumes sync_n is already synchronous to clk.
module sync_req_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic sync_req
);

    logic low_q;

    // Remember whether sync_n was low at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= 1'b0;
        end else begin
            low_q <= ~sync_n;
        end
    end

    // Request is qualified on the second consecutive low sample.
    always_comb begin
        sync_req = ~sync_n & low_q;
    end

endmodule

// File: rtl/link_state_fsm.sv
// Module: link_state_fsm
// Holds the link state (comma / alignment / data) and the alignment position
// counters. Leaves the comma state only at a frame end with sync released, so
// the next octet is frame octet 0. Assumes frm_end marks the last octet of
// every frame and cfg inputs are static while aligning.
module link_state_fsm
    import link_sync_pkg::*;
#(
    parameter int MF_CNT_W = 5,
    parameter int ALIGN_MF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_req,
    input  logic                sync_n,
    input  logic                frm_end,
    input  logic                cfg_align_en,
    input  logic [MF_CNT_W-1:0] cfg_mf_len_m1,
    output link_st_e            st,
    output logic                mf_start,
    output logic                mf_end
);

    localparam int MFI_W = (ALIGN_MF > 2) ? $clog2(ALIGN_MF) : 1;
    localparam logic [MFI_W-1:0] MF_LAST = MFI_W'(ALIGN_MF - 1);

    link_st_e            st_q, st_d;
    logic [MF_CNT_W-1:0] fr_q;
    logic [MFI_W-1:0]    mf_q;
    logic                first_q;

    // Marker positions inside the alignment sequence.
    always_comb begin
        mf_start = (st_q == ST_ALIGN) && first_q && (fr_q == '0);
        mf_end   = (st_q == ST_ALIGN) && frm_end && (fr_q == cfg_mf_len_m1);
    end

    // Next-state decision; a qualified request overrides everything.
    always_comb begin
        st_d = st_q;
        if (sync_req) begin
            st_d = ST_SYNC;
        end else begin
            case (st_q)
                ST_SYNC:  if (sync_n && frm_end) st_d = cfg_align_en ? ST_ALIGN : ST_DATA;
                ST_ALIGN: if (mf_end && (mf_q == MF_LAST)) st_d = ST_DATA;
                ST_DATA:  st_d = ST_DATA;
                default:  st_d = ST_SYNC;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_SYNC;
        end else begin
            st_q <= st_d;
        end
    end

    // Frame-start tracker: the octet after a frame end is frame octet 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else begin
            first_q <= frm_end;
        end
    end

    // Frame and multiframe counters, active only while aligning.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_ALIGN || sync_req) begin
            fr_q <= '0;
            mf_q <= '0;
        end else if (frm_end) begin
            if (fr_q == cfg_mf_len_m1) begin
                fr_q <= '0;
                mf_q <= mf_q + 1'b1;
            end else begin
                fr_q <= fr_q + 1'b1;
            end
        end
    end

    always_comb begin
        st = st_q;
    end

    // R7: alignment persists until the final multiframe ends or a request.
    p_align_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALIGN && !sync_req && !(mf_end && mf_q == MF_LAST)) |=> (st_q == ST_ALIGN));

    // R7: frame counter never exceeds the configured multiframe length.
    p_frame_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALIGN) |-> (fr_q <= cfg_mf_len_m1));

endmodule

// File: rtl/lane_symbol_gen.sv
// Module: lane_symbol_gen
// Maps link state and alignment marker positions onto one lane's select,
// K flag and control octet code. Purely combinational; one per lane.
module lane_symbol_gen
    import link_sync_pkg::*;
(
    input  link_st_e  st,
    input  logic      mf_start,
    input  logic      mf_end,
    output lane_ctl_t ctl
);

    // Choose the lane's octet source and control code.
    always_comb begin
        ctl = '{sel: SEL_DATA, k: 1'b0, code: 8'h00};
        case (st)
            ST_SYNC: begin
                ctl = '{sel: SEL_COMMA, k: 1'b1, code: CODE_COMMA};
            end
            ST_ALIGN: begin
                ctl.sel = SEL_ALIGN;
                if (mf_end) begin
                    ctl.k    = 1'b1;
                    ctl.code = CODE_MF_END;
                end else if (mf_start) begin
                    ctl.k    = 1'b1;
                    ctl.code = CODE_MF_START;
                end
            end
            default: begin
                ctl = '{sel: SEL_DATA, k: 1'b0, code: 8'h00};
            end
        endcase
    end

endmodule

// File: rtl/link_sync_ctrl.sv
// Module: link_sync_ctrl (top)
// Transmit-side comma synchronisation controller for NUM_LANES lanes.
// Filters the receiver request, runs the link state machine and fans the
// per-lane symbol decision out to every lane. Assumes frm_end is high on the
// last octet of each frame and all lanes share one frame timing.
module link_sync_ctrl
    import link_sync_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int MF_CNT_W  = 5,
    parameter int ALIGN_MF  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_n,
    input  logic                   frm_end,
    input  logic                   cfg_align_en,
    input  logic [MF_CNT_W-1:0]    cfg_mf_len_m1,
    output logic [2*NUM_LANES-1:0] lane_sel,
    output logic [NUM_LANES-1:0]   lane_k,
    output logic [8*NUM_LANES-1:0] lane_code
);

    logic      sync_req;
    link_st_e  st;
    logic      mf_start;
    logic      mf_end;
    lane_ctl_t ctl [NUM_LANES];

    sync_req_filter u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .sync_req (sync_req)
    );

    link_state_fsm #(
        .MF_CNT_W (MF_CNT_W),
        .ALIGN_MF (ALIGN_MF)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_req      (sync_req),
        .sync_n        (sync_n),
        .frm_end       (frm_end),
        .cfg_align_en  (cfg_align_en),
        .cfg_mf_len_m1 (cfg_mf_len_m1),
        .st            (st),
        .mf_start      (mf_start),
        .mf_end        (mf_end)
    );

    // One symbol generator per lane, flattened onto the port vectors.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        lane_symbol_gen u_gen (
            .st       (st),
            .mf_start (mf_start),
            .mf_end   (mf_end),
            .ctl      (ctl[i])
        );
        always_comb begin
            lane_sel[2*i +: 2]  = ctl[i].sel;
            lane_k[i]           = ctl[i].k;
            lane_code[8*i +: 8] = ctl[i].code;
        end
    end

    // Assertion support: marks that one full cycle has passed since reset.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: two consecutive low samples force commas in the next cycle.
    p_two_low_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !sync_n && !$past(sync_n)) |=> (lane_sel[1:0] == SEL_COMMA && lane_k[0]));

    // R3: a first low sample in the data state does not leave data.
    p_glitch_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st == ST_DATA && !sync_n && $past(sync_n)) |=> (st == ST_DATA));

    // R5: leaving commas happens only after a released frame end.
    p_exit_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(lane_sel[1:0]) == SEL_COMMA && lane_sel[1:0] != SEL_COMMA)
            |-> $past(frm_end && sync_n));

endmodule

// File: tb/link_sync_ctrl_bench.sv
// Bench: sweeps frame length, multiframe length, alignment enable and release
// phase; a behavioural model built from the requirements predicts every cycle.
module link_sync_ctrl_bench;

    localparam int NL = 2;
    localparam int MW = 5;
    localparam int AMF = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync_n = 1'b0;
    logic            frm_end = 1'b0;
    logic            cfg_align_en = 1'b0;
    logic [MW-1:0]   cfg_mf_len_m1 = '0;
    logic [2*NL-1:0] lane_sel;
    logic [NL-1:0]   lane_k;
    logic [8*NL-1:0] lane_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    link_sync_ctrl #(.NUM_LANES(NL), .MF_CNT_W(MW), .ALIGN_MF(AMF)) u_link_sync_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_n        (sync_n),
        .frm_end       (frm_end),
        .cfg_align_en  (cfg_align_en),
        .cfg_mf_len_m1 (cfg_mf_len_m1),
        .lane_sel      (lane_sel),
        .lane_k        (lane_k),
        .lane_code     (lane_code)
    );

    // Model state: 0 comma, 1 alignment, 2 data.
    int m_st = 0;
    bit m_prev_low = 0;
    bit m_first = 0;
    int m_fr = 0;
    int m_mf = 0;
    int flen = 1;
    int pos = 0;

    task automatic check_lanes(input string tag, input int es, input int ek, input int ec);
        checks++;
        for (int i = 0; i < NL; i++) begin
            if (int'(lane_sel[2*i +: 2]) != es || int'(lane_k[i]) != ek ||
                int'(lane_code[8*i +: 8]) != ec) begin
                failures++;
                $display("FAIL %s/R10 lane %0d sel=%0d k=%0d code=%0h expected sel=%0d k=%0d code=%0h",
                         tag, i, lane_sel[2*i +: 2], lane_k[i], lane_code[8*i +: 8], es, ek, ec);
            end
        end
    endtask

    // One clock: drive inputs, check predicted outputs, advance the model.
    task automatic step(input logic s_n, input string tag_ovr);
        int es, ek, ec;
        string tag;
        bit req;
        @(negedge clk);
        sync_n  = s_n;
        frm_end = (pos == flen - 1);
        #1;
        es = m_st; ek = 0; ec = 0; tag = "R6/R9";
        if (m_st == 0) begin
            ek = 1; ec = 'hBC; tag = "R4";
        end else if (m_st == 1) begin
            tag = "R7";
            if (frm_end && m_fr == int'(cfg_mf_len_m1)) begin
                ek = 1; ec = 'h7C; tag = "R8";
            end else if (m_first && m_fr == 0) begin
                ek = 1; ec = 'h1C; tag = "R8";
            end
        end
        if (tag_ovr != "") tag = tag_ovr;
        check_lanes(tag, es, ek, ec);
        @(posedge clk);
        req = !s_n && m_prev_low;
        if (req) begin
            m_st = 0; m_fr = 0; m_mf = 0;
        end else if (m_st == 0) begin
            if (s_n && frm_end) m_st = cfg_align_en ? 1 : 2;
        end else if (m_st == 1 && frm_end) begin
            if (m_fr == int'(cfg_mf_len_m1)) begin
                m_fr = 0;
                if (m_mf == AMF - 1) begin m_st = 2; m_mf = 0; end
                else m_mf++;
            end else m_fr++;
        end
        m_prev_low = !s_n;
        m_first = frm_end;
        pos = (pos == flen - 1) ? 0 : pos + 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state is comma on every lane.
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check_lanes("R1", 0, 1, 'hBC);
        rst_n = 1'b1;
        for (int f = 1; f <= 3; f++) begin
            for (int km = 0; km <= 2; km++) begin
                for (int en = 0; en <= 1; en++) begin
                    for (int ph = 0; ph < f; ph++) begin
                        flen = f; pos = 0;
                        cfg_mf_len_m1 = MW'(km);
                        cfg_align_en = en[0];
                        // R2/R4: request and hold commas over several frames.
                        step(1'b0, ""); step(1'b0, "");
                        for (int c = 0; c < 2 * f + 1; c++) step(1'b0, "R4");
                        // R5: release at phase ph, commas until the frame end.
                        while (pos != ph) step(1'b0, "");
                        for (int c = 0; c < AMF * (km + 1) * f + 3 * f + 2; c++) step(1'b1, "");
                        // R3: single-edge glitch in data is ignored.
                        step(1'b0, "R3"); step(1'b1, "R3"); step(1'b1, "R3");
                        // R2: two lows force commas on the following cycle.
                        step(1'b0, ""); step(1'b0, "R2"); step(1'b0, "R2");
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule